// File: doc/BRIEF.md
# Card Memory and I/O Address Decoder

This block turns a 20-bit address, an I/O-cycle qualifier and two board straps into active-low chip selects for a processor card. The card carries a 32 KB RAM, a 32 KB ROM, a 16550-style UART register window and an 8-byte control port. Together the RAM and ROM fill one 64 KB block. A strap moves that block between two positions in the address space. A second strap moves the 16-byte I/O block between two bases.

A 4 KB window at local offsets 0xD000-0xDFFF is handed to the backplane. Any access there drives an active-low external I/O strobe and keeps the local ROM quiet. A control-port bit can close this window, and the ROM then answers at those offsets like anywhere else in its half. The decoder is purely combinational and holds no state.

Top module: `card_addr_dec`

## Requirements
- R1: With `io_space`=0 and the address inside the selected 64 KB block, local offsets 0x0000-0x7FFF drive `ram_sel_n` low.
- R2: With `io_space`=0 and the address inside the selected block, local offsets 0x8000-0xFFFF drive `rom_sel_n` low, except where R6 applies.
- R3: `bank_hi`=0 places the block at 0x00000-0x0FFFF and `bank_hi`=1 places it at 0x30000-0x3FFFF (address bits 19:16 equal 0x0 or 0x3). Addresses outside the selected block assert no memory select and no strobe.
- R4: With `io_space`=1, address bits 11:0 at base+0..base+7 drive `port_sel_n` low, and at base+8..base+15 they drive `uart_sel_n` low. Address bits 19:12 are ignored for I/O.
- R5: `io_base_alt`=0 sets the I/O base to 0xFE0 and `io_base_alt`=1 sets it to 0xFC0. The unselected base decodes nothing.
- R6: With `win_off`=0, a memory access to local offsets 0xD000-0xDFFF of the selected block drives `extio_n` low and holds `rom_sel_n` high.
- R7: With `win_off`=1, `extio_n` stays high for every input, and offsets 0xD000-0xDFFF select the ROM.
- R8: The UART and port selects assert only when `io_space`=1. The RAM, ROM and strobe outputs assert only when `io_space`=0.
- R9: For every address, qualifier and strap combination, at most one of the five active-low outputs is low.
- R10: All outputs are combinational functions of the current inputs. A change of the inputs is reflected without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 20 | Address bus |
| io_space | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| bank_hi | input | 1 | Strap: 0 = block at 0x0xxxx, 1 = block at 0x3xxxx |
| io_base_alt | input | 1 | Strap: 0 = I/O base 0xFE0, 1 = I/O base 0xFC0 |
| win_off | input | 1 | Control bit: 1 closes the external I/O window |
| ram_sel_n | output | 1 | RAM chip select, active low |
| rom_sel_n | output | 1 | ROM chip select, active low |
| uart_sel_n | output | 1 | UART register select, active low |
| port_sel_n | output | 1 | Control port select, active low |
| extio_n | output | 1 | External I/O window strobe, active low |

## Verification
Two decodes compete for the same address in this block. The first is the window strobe against the ROM select, both at offsets 0xDxxx. The second is the memory decode against the I/O decode, because an address such as 0x00FE0 matches both and only the qualifier separates them. The bench provokes both by driving the boundary addresses 0xCFFF/0xD000/0xDFFF/0xE000 with the window open and closed, and by presenting I/O-base addresses in memory cycles and memory addresses in I/O cycles. It then runs a sweep over every address class and all sixteen qualifier, strap and window combinations. Each vector is judged against a behavioural model written with integer ranges, and the sweep also confirms that no more than one output is low.

// File: rtl/card_dec_pkg.sv
`timescale 1ns/10ps
package card_dec_pkg;

  localparam logic [3:0] BANK_TAG_LO  = 4'h0;
  localparam logic [3:0] BANK_TAG_HI  = 4'h3;
  localparam logic [7:0] IO_TAG_MAIN  = 8'hFE;
  localparam logic [7:0] IO_TAG_ALT   = 8'hFC;
  localparam logic [3:0] WIN_NIBBLE   = 4'hD;

  typedef struct packed {
    logic ram_n;
    logic rom_n;
    logic uart_n;
    logic port_n;
    logic extio_n;
  } sel_bus_t;

  // upper address nibble that the memory block answers to
  function automatic logic [3:0] bank_tag(input logic hi);
    return hi ? BANK_TAG_HI : BANK_TAG_LO;
  endfunction

  // address bits 11:4 that the I/O block answers to
  function automatic logic [7:0] io_tag(input logic alt);
    return alt ? IO_TAG_ALT : IO_TAG_MAIN;
  endfunction

endpackage

// File: rtl/card_mem_dec.sv
`timescale 1ns/10ps
module card_mem_dec #(
  parameter int ADDR_W = 20,
  parameter int BLK_W  = 16,
  parameter int WIN_W  = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              io_space,
  input  logic              bank_hi,
  input  logic              win_off,
  output logic              ram_n,
  output logic              rom_n,
  output logic              extio_n,
  output logic              mem_hit,
  output logic              win_hit
);
  localparam int TAG_W = ADDR_W - BLK_W;
  localparam int NIB_W = BLK_W - WIN_W;

  logic [TAG_W-1:0] blk_tag;
  logic [NIB_W-1:0] blk_nib;
  logic             low_half;
  logic             strobe;

  assign blk_tag  = addr[ADDR_W-1:BLK_W];
  assign blk_nib  = addr[BLK_W-1:WIN_W];
  assign low_half = ~addr[BLK_W-1];

  assign mem_hit = ~io_space &&
                   (blk_tag == TAG_W'(card_dec_pkg::bank_tag(bank_hi)));
  assign win_hit = mem_hit && (blk_nib == NIB_W'(card_dec_pkg::WIN_NIBBLE));
  assign strobe  = win_hit && ~win_off;

  assign ram_n   = ~(mem_hit && low_half);
  assign rom_n   = ~(mem_hit && ~low_half && ~strobe);
  assign extio_n = ~strobe;
endmodule

// File: rtl/card_io_dec.sv
`timescale 1ns/10ps
module card_io_dec #(
  parameter int IO_W  = 12,
  parameter int REG_W = 4
) (
  input  logic [IO_W-1:0] io_addr,
  input  logic            io_space,
  input  logic            base_alt,
  output logic            port_n,
  output logic            uart_n,
  output logic            io_hit
);
  localparam int TAG_W = IO_W - REG_W;

  logic [TAG_W-1:0] tag;
  logic             upper;

  assign tag    = io_addr[IO_W-1:REG_W];
  assign upper  = io_addr[REG_W-1];
  assign io_hit = io_space && (tag == TAG_W'(card_dec_pkg::io_tag(base_alt)));
  assign port_n = ~(io_hit && ~upper);
  assign uart_n = ~(io_hit && upper);
endmodule

// File: rtl/card_addr_dec.sv
`timescale 1ns/10ps
module card_addr_dec #(
  parameter int ADDR_W = 20,
  parameter int BLK_W  = 16,
  parameter int WIN_W  = 12,
  parameter int IO_W   = 12,
  parameter int REG_W  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              io_space,
  input  logic              bank_hi,
  input  logic              io_base_alt,
  input  logic              win_off,
  output logic              ram_sel_n,
  output logic              rom_sel_n,
  output logic              uart_sel_n,
  output logic              port_sel_n,
  output logic              extio_n
);
  // decode events brought out for the checker
  logic mem_hit;
  logic win_hit;
  logic io_hit;
  card_dec_pkg::sel_bus_t sel;

  card_mem_dec #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .WIN_W(WIN_W)) u_mem (
    .addr    (addr),
    .io_space(io_space),
    .bank_hi (bank_hi),
    .win_off (win_off),
    .ram_n   (sel.ram_n),
    .rom_n   (sel.rom_n),
    .extio_n (sel.extio_n),
    .mem_hit (mem_hit),
    .win_hit (win_hit)
  );

  card_io_dec #(.IO_W(IO_W), .REG_W(REG_W)) u_io (
    .io_addr (addr[IO_W-1:0]),
    .io_space(io_space),
    .base_alt(io_base_alt),
    .port_n  (sel.port_n),
    .uart_n  (sel.uart_n),
    .io_hit  (io_hit)
  );

  assign ram_sel_n  = sel.ram_n;
  assign rom_sel_n  = sel.rom_n;
  assign uart_sel_n = sel.uart_n;
  assign port_sel_n = sel.port_n;
  assign extio_n    = sel.extio_n;
endmodule

// File: rtl/card_addr_dec_chk.sv
`timescale 1ns/10ps
module card_addr_dec_chk (
  input logic io_space,
  input logic win_off,
  input logic mem_hit,
  input logic win_hit,
  input logic io_hit,
  input logic ram_sel_n,
  input logic rom_sel_n,
  input logic uart_sel_n,
  input logic port_sel_n,
  input logic extio_n
);
  logic [4:0] sels_n;
  assign sels_n = {ram_sel_n, rom_sel_n, uart_sel_n, port_sel_n, extio_n};

  always_comb begin
    if (!$isunknown({sels_n, io_space, win_off, mem_hit, win_hit, io_hit})) begin
      // R9
      one_sel_chk: assert ($countones(~sels_n) <= 1)
        else $error("more than one select low: %b", sels_n);
      // R8
      io_only_chk: assert (!(uart_sel_n == 1'b0 || port_sel_n == 1'b0) || (io_space && io_hit))
        else $error("I/O select outside I/O cycle");
      // R8
      mem_only_chk: assert (!(ram_sel_n == 1'b0 || rom_sel_n == 1'b0 || extio_n == 1'b0) ||
                            (!io_space && mem_hit))
        else $error("memory select outside memory cycle");
      // R6
      win_rom_chk: assert (extio_n || (rom_sel_n && win_hit))
        else $error("strobe outside window or with ROM");
      // R7
      win_off_chk: assert (!win_off || extio_n)
        else $error("strobe while window closed");
    end
  end
endmodule

bind card_addr_dec card_addr_dec_chk u_chk (
  .io_space  (io_space),
  .win_off   (win_off),
  .mem_hit   (mem_hit),
  .win_hit   (win_hit),
  .io_hit    (io_hit),
  .ram_sel_n (ram_sel_n),
  .rom_sel_n (rom_sel_n),
  .uart_sel_n(uart_sel_n),
  .port_sel_n(port_sel_n),
  .extio_n   (extio_n)
);

// File: tb/tb_card_addr_dec.sv
`timescale 1ns/10ps
module tb_card_addr_dec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] addr;
  logic        io_space, bank_hi, io_base_alt, win_off;
  logic        ram_sel_n, rom_sel_n, uart_sel_n, port_sel_n, extio_n;
  int          errors = 0;
  int          checks = 0;
  bit          live_cmp = 1'b0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  card_addr_dec dut (
    .addr(addr), .io_space(io_space), .bank_hi(bank_hi),
    .io_base_alt(io_base_alt), .win_off(win_off),
    .ram_sel_n(ram_sel_n), .rom_sel_n(rom_sel_n), .uart_sel_n(uart_sel_n),
    .port_sel_n(port_sel_n), .extio_n(extio_n)
  );

  // behavioural model: returns {ram,rom,uart,port,extio}, active low
  function automatic logic [4:0] model(input int a, input bit io, input bit bk,
                                       input bit alt, input bit woff);
    logic [4:0] r = 5'b11111;
    int blk  = bk ? 3 : 0;
    int off  = a % 65536;
    int low  = a % 4096;
    int base = alt ? 'hFC0 : 'hFE0;
    if (!io && (a / 65536) == blk) begin
      if (off < 32768)                      r[4] = 1'b0;
      else if ((off / 4096) == 13 && !woff) r[0] = 1'b0;
      else                                  r[3] = 1'b0;
    end
    if (io && low >= base && low < base + 8)       r[1] = 1'b0;
    if (io && low >= base + 8 && low < base + 16)  r[2] = 1'b0;
    return r;
  endfunction

  function automatic logic [4:0] outs();
    return {ram_sel_n, rom_sel_n, uart_sel_n, port_sel_n, extio_n};
  endfunction

  task automatic judge(input string req, input logic [4:0] exp);
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL %s addr=%h io=%0b bank=%0b alt=%0b woff=%0b actual=%b expected=%b",
               req, addr, io_space, bank_hi, io_base_alt, win_off, outs(), exp);
    end
  endtask

  task automatic apply(input logic [19:0] a, input bit io, input bit bk,
                       input bit alt, input bit woff);
    addr = a; io_space = io; bank_hi = bk; io_base_alt = alt; win_off = woff;
  endtask

  // directed vector: drive after a rising edge, check before the falling edge
  task automatic vec(input string req, input logic [19:0] a, input bit io,
                     input bit bk, input bit alt, input bit woff, input logic [4:0] exp);
    @(posedge clk);
    #1;
    apply(a, io, bk, alt, woff);
    #1;
    judge(req, exp);
    judge({req, "-model"}, model(int'(a), io, bk, alt, woff));
  endtask

  // reference comparison on every clock during the directed phase
  always @(negedge clk) begin
    if (live_cmp && !rst)
      judge("R10-clock", model(int'(addr), io_space, bank_hi, io_base_alt, win_off));
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    apply(20'h00000, 1'b1, 1'b0, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #2;
    judge("R8-idle", 5'b11111);
    live_cmp = 1'b1;

    // R1 RAM half
    vec("R1", 20'h00000, 0, 0, 0, 0, 5'b01111);
    vec("R1", 20'h07FFF, 0, 0, 0, 0, 5'b01111);
    // R2 ROM half
    vec("R2", 20'h08000, 0, 0, 0, 0, 5'b10111);
    vec("R2", 20'h0FFFF, 0, 0, 0, 0, 5'b10111);
    vec("R2", 20'h0E000, 0, 0, 0, 0, 5'b10111);
    // R6 window open, boundaries
    vec("R6", 20'h0CFFF, 0, 0, 0, 0, 5'b10111);
    vec("R6", 20'h0D000, 0, 0, 0, 0, 5'b11110);
    vec("R6", 20'h0DFFF, 0, 0, 0, 0, 5'b11110);
    // R7 window closed
    vec("R7", 20'h0D000, 0, 0, 0, 1, 5'b10111);
    vec("R7", 20'h0DFFF, 0, 0, 0, 1, 5'b10111);
    vec("R7", 20'h0D000, 1, 0, 0, 1, 5'b11111);
    // R3 bank strap
    vec("R3", 20'h00000, 0, 1, 0, 0, 5'b11111);
    vec("R3", 20'h30000, 0, 1, 0, 0, 5'b01111);
    vec("R3", 20'h3D800, 0, 1, 0, 0, 5'b11110);
    vec("R3", 20'h3D800, 0, 0, 0, 0, 5'b11111);
    vec("R3", 20'h10000, 0, 0, 0, 0, 5'b11111);
    vec("R3", 20'h2FFFF, 0, 1, 0, 0, 5'b11111);
    // R4 I/O block at main base
    vec("R4", 20'h00FE0, 1, 0, 0, 0, 5'b11101);
    vec("R4", 20'h00FE7, 1, 0, 0, 0, 5'b11101);
    vec("R4", 20'h00FE8, 1, 0, 0, 0, 5'b11011);
    vec("R4", 20'h00FEF, 1, 0, 0, 0, 5'b11011);
    vec("R4", 20'h00FF0, 1, 0, 0, 0, 5'b11111);
    vec("R4", 20'h00FDF, 1, 0, 0, 0, 5'b11111);
    vec("R4", 20'hA5FE9, 1, 0, 0, 0, 5'b11011);
    // R5 I/O base strap
    vec("R5", 20'h00FC0, 1, 0, 0, 0, 5'b11111);
    vec("R5", 20'h00FC3, 1, 0, 1, 0, 5'b11101);
    vec("R5", 20'h00FC8, 1, 0, 1, 0, 5'b11011);
    vec("R5", 20'h00FE0, 1, 0, 1, 0, 5'b11111);
    // R8 qualifier separates decodes
    vec("R8", 20'h00FE0, 0, 0, 0, 0, 5'b01111);
    vec("R8", 20'h08000, 1, 0, 0, 0, 5'b11111);
    vec("R8", 20'h0D000, 1, 0, 0, 0, 5'b11111);
    vec("R8", 20'h0DFE8, 1, 0, 0, 0, 5'b11011);

    // R10: outputs follow an input change with no clock edge in between
    @(posedge clk);
    #1;
    apply(20'h0D123, 0, 0, 0, 0);
    #0.5;
    judge("R10", 5'b11110);
    win_off = 1'b1;
    #0.5;
    judge("R10", 5'b10111);
    io_space = 1'b1;
    addr = 20'h00FEC;
    #0.5;
    judge("R10", 5'b11011);
    live_cmp = 1'b0;

    // R9 sweep over all address classes and all combinations
    @(posedge clk);
    for (int combo = 0; combo < 16; combo++) begin
      for (int a = 0; a < 1048576; a += 8) begin
        int av = a | ((a >> 3) & 7);
        apply(20'(av), combo[0], combo[1], combo[2], combo[3]);
        #0.25;
        checks++;
        if ($countones(~outs()) > 1) begin
          errors++;
          $display("FAIL R9 addr=%h combo=%0d actual=%b expected=at most one low",
                   addr, combo, outs());
        end
        judge("R9-model", model(av, combo[0], combo[1], combo[2], combo[3]));
        #0.25;
      end
    end

    finish_run();
  end
endmodule